// File: doc/BRIEF.md
# Butterfly Input Vector Generator

This block sits in front of a multiplier-free 8-point cosine transform stage. Signed 8-bit samples arrive one per clock, qualified by a valid strobe, and are parked in a bank of eight registers. A modulo-8 write pointer advances only on accepted samples.

When the eighth sample of a group is accepted, the whole set is folded at once into the pairwise sums and differences that the fast factorization needs. The results go into a second bank, which is played out one 9-bit element per clock, together with its position. Because the played-out bank is separate from the capture bank, the next group can be collected while the current one is still being emitted. An unbroken input stream therefore gives an unbroken output stream.

Top module: `bfly_vecgen`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_idx` is 0, and the capture pointer starts at slot 0. The first accepted sample after reset is therefore sample 0 of a group.
- R2: A clock with `in_valid` low does not store its sample and does not advance the capture pointer. Such samples never appear in any output element.
- R3: `out_valid` rises in the cycle right after the clock edge that accepts the eighth sample of a group, with `out_idx` = 0.
- R4: Samples are 8-bit two's complement. For k = 0..3, output element k is x[k] + x[7-k], where x[j] is the j-th accepted sample of the group. It is given as a 9-bit two's complement value.
- R5: For k = 0..3, output element 4+k is x[k] - x[7-k], given as 9-bit two's complement.
- R6: For each group, `out_valid` is high for exactly eight consecutive cycles, with `out_idx` stepping 0,1,...,7. When nothing is being emitted, `out_idx` is 0.
- R7: If the next group's eighth sample is accepted on the same edge that ends the current group's index 7, emission continues with no idle cycle. The new group's index 0 follows directly, and neither group is corrupted.
- R8: Extreme inputs (+127, -128) produce sums of +254 and -256 and differences of +255 and -255, all without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | 8 | Signed input sample |
| out_valid | output | 1 | `out_elem` and `out_idx` are meaningful |
| out_elem | output | 9 | Signed butterfly sum or difference |
| out_idx | output | 3 | Position of `out_elem` within the group (0..7) |

## Verification
The two functions that can land on one edge are the loading of a freshly folded group and the end of the previous group's play-out. This happens when the input streams with no gaps. The bench sends two groups back to back with `in_valid` held high for sixteen cycles. It then judges that sixteen valid cycles follow in strict sequence and that the second index 0 comes exactly one cycle after the first index 7. Each element must match sums and differences computed in the bench from the samples it sent.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    localparam int DEF_SAMPLE_W = 8;
    localparam int DEF_GROUP_N  = 8;

    // bits needed to address n slots (at least one)
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bfly_capture.sv
module bfly_capture #(
    parameter int SAMPLE_W = 8,
    parameter int GROUP_N  = 8,
    parameter int IDX_W    = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [SAMPLE_W-1:0]                in_sample,
    output logic [GROUP_N-1:0][SAMPLE_W-1:0]   grp_vec,
    output logic                               grp_done
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(GROUP_N - 1);

    typedef struct packed {
        logic [IDX_W-1:0]                     ptr;
        logic [GROUP_N-1:0][SAMPLE_W-1:0]     bank;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        grp_done = 1'b0;
        if (in_valid) begin
            st_d.bank[st_q.ptr] = in_sample;
            if (st_q.ptr == LAST_SLOT) begin
                st_d.ptr = '0;
                grp_done = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
        // the group seen by the adders includes the sample arriving now
        grp_vec = st_d.bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bfly_fold.sv
module bfly_fold #(
    parameter int SAMPLE_W = 8,
    parameter int GROUP_N  = 8
) (
    input  logic [GROUP_N-1:0][SAMPLE_W-1:0]   x_in,
    output logic [GROUP_N-1:0][SAMPLE_W:0]     y_out
);

    localparam int HALF = GROUP_N / 2;

    for (genvar k = 0; k < HALF; k++) begin : g_pair
        logic [SAMPLE_W:0] lo_ext;
        logic [SAMPLE_W:0] hi_ext;

        assign lo_ext = {x_in[k][SAMPLE_W-1], x_in[k]};
        assign hi_ext = {x_in[GROUP_N-1-k][SAMPLE_W-1], x_in[GROUP_N-1-k]};

        assign y_out[k]        = lo_ext + hi_ext;
        assign y_out[HALF + k] = lo_ext - hi_ext;
    end

endmodule

// File: rtl/bfly_emit.sv
module bfly_emit #(
    parameter int ELEM_W  = 9,
    parameter int GROUP_N = 8,
    parameter int IDX_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [GROUP_N-1:0][ELEM_W-1:0]   load_vec,
    output logic                             out_valid,
    output logic [ELEM_W-1:0]                out_elem,
    output logic [IDX_W-1:0]                 out_idx
);

    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(GROUP_N - 1);

    typedef struct packed {
        logic                              busy;
        logic [IDX_W-1:0]                  pos;
        logic [GROUP_N-1:0][ELEM_W-1:0]    bank;
    } emit_t;

    emit_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.bank = load_vec;
            st_d.pos  = '0;
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            if (st_q.pos == LAST_POS) begin
                st_d.pos  = '0;
                st_d.busy = 1'b0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.busy;
    assign out_idx   = st_q.pos;
    assign out_elem  = st_q.bank[st_q.pos];

endmodule

// File: rtl/bfly_vecgen.sv
module bfly_vecgen #(
    parameter int SAMPLE_W = bfly_pkg::DEF_SAMPLE_W,
    parameter int GROUP_N  = bfly_pkg::DEF_GROUP_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_sample,
    output logic                 out_valid,
    output logic [SAMPLE_W:0]    out_elem,
    output logic [bfly_pkg::idx_bits(GROUP_N)-1:0] out_idx
);

    localparam int ELEM_W = SAMPLE_W + 1;
    localparam int IDX_W  = bfly_pkg::idx_bits(GROUP_N);

    logic [GROUP_N-1:0][SAMPLE_W-1:0] grp_vec;
    logic [GROUP_N-1:0][ELEM_W-1:0]   fold_vec;
    logic                             grp_done;

    bfly_capture #(
        .SAMPLE_W (SAMPLE_W),
        .GROUP_N  (GROUP_N),
        .IDX_W    (IDX_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .grp_vec   (grp_vec),
        .grp_done  (grp_done)
    );

    bfly_fold #(
        .SAMPLE_W (SAMPLE_W),
        .GROUP_N  (GROUP_N)
    ) u_fold (
        .x_in  (grp_vec),
        .y_out (fold_vec)
    );

    bfly_emit #(
        .ELEM_W  (ELEM_W),
        .GROUP_N (GROUP_N),
        .IDX_W   (IDX_W)
    ) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (grp_done),
        .load_vec  (fold_vec),
        .out_valid (out_valid),
        .out_elem  (out_elem),
        .out_idx   (out_idx)
    );

endmodule

// File: rtl/bfly_vecgen_chk.sv
module bfly_vecgen_chk #(
    parameter int SAMPLE_W = 8,
    parameter int GROUP_N  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [SAMPLE_W:0]    out_elem,
    input logic [bfly_pkg::idx_bits(GROUP_N)-1:0] out_idx
);

    localparam int IDX_W = bfly_pkg::idx_bits(GROUP_N);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(GROUP_N - 1);

    // independent tally of accepted samples within the current group
    logic [IDX_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (in_valid) begin
            seen_q <= (seen_q == LAST) ? '0 : seen_q + 1'b1;
        end
    end

    AST_LAUNCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seen_q == LAST) |=> (out_valid && out_idx == '0)); // R3

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx != LAST) |=> (out_valid && out_idx == $past(out_idx) + 1'b1)); // R6

    AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx == LAST && !(in_valid && seen_q == LAST)) |=> !out_valid); // R6

    AST_CHAIN_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx == LAST && in_valid && seen_q == LAST) |=> (out_valid && out_idx == '0)); // R7

    AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_idx == '0); // R1

    AST_ELEM_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_elem)); // R4

endmodule

bind bfly_vecgen bfly_vecgen_chk #(
    .SAMPLE_W (SAMPLE_W),
    .GROUP_N  (GROUP_N)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_elem  (out_elem),
    .out_idx   (out_idx)
);

// File: tb/bfly_vecgen_test.sv
module bfly_vecgen_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_sample = '0;
    logic       out_valid;
    logic [8:0] out_elem;
    logic [2:0] out_idx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_cyc = 0;
    bit done = 1'b0;

    int obs_n = 0;
    int obs_idx [64];
    int obs_val [64];
    int obs_cyc [64];

    bfly_vecgen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_elem  (out_elem),
        .out_idx   (out_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // record every valid output, away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && obs_n < 64) begin
            obs_idx[obs_n] = int'(out_idx);
            obs_val[obs_n] = int'($signed(out_elem));
            obs_cyc[obs_n] = cyc;
            obs_n = obs_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fold_ref(input int xs[8], input int k);
        if (k < 4) return xs[k] + xs[7-k];
        return xs[k-4] - xs[11-k];
    endfunction

    task automatic send_group(input int xs[8], input int gap);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 8'(xs[k]);
            if (k != 7) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid  = 1'b0;
                    in_sample = 8'h55;
                end
            end
        end
        last_cyc = cyc;
    endtask

    task automatic go_idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = 8'hA3;
        end
    endtask

    task automatic check_group(input string req, input int xs[8], input int base, input int end_cyc);
        chk("R3", {req, " latency"}, obs_cyc[base] - end_cyc, 1);
        for (int k = 0; k < 8; k++) begin
            chk("R6", {req, " index"}, obs_idx[base+k], k);
            chk("R6", {req, " contiguous"}, obs_cyc[base+k] - obs_cyc[base], k);
            chk(k < 4 ? "R4" : "R5", {req, " element"}, obs_val[base+k], fold_ref(xs, k));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "out_idx after reset", int'(out_idx), 0);
        obs_n = 0;
        go_idle(12);
        chk("R2", "no output without valid input", obs_n, 0);
    endtask

    task automatic t_ramp();
        int xs[8] = '{1, 2, 3, 4, 5, 6, 7, 8};
        obs_n = 0;
        send_group(xs, 0);
        go_idle(14);
        chk("R6", "ramp element count", obs_n, 8);
        check_group("ramp", xs, 0, last_cyc);
    endtask

    task automatic t_gaps();
        int xs[8] = '{-3, 40, -17, 9, 100, -64, 2, -90};
        obs_n = 0;
        send_group(xs, 2);
        go_idle(14);
        chk("R2", "gapped element count", obs_n, 8);
        check_group("R2 gapped", xs, 0, last_cyc);
    endtask

    task automatic t_extremes();
        int xa[8] = '{127, -128, 127, -1, 0, 127, -128, 127};
        int xb[8] = '{127, -128, 0, 0, 0, 0, 127, -128};
        obs_n = 0;
        send_group(xa, 0);
        go_idle(12);
        check_group("R8 extA", xa, 0, last_cyc);
        chk("R8", "sum +254", obs_val[0], 254);
        chk("R8", "sum -256", obs_val[1], -256);
        obs_n = 0;
        send_group(xb, 0);
        go_idle(12);
        check_group("R8 extB", xb, 0, last_cyc);
        chk("R8", "diff +255", obs_val[4], 255);
        chk("R8", "diff -255", obs_val[5], -255);
    endtask

    task automatic t_stream();
        int xa[8] = '{10, -20, 30, -40, 50, -60, 70, -80};
        int xb[8] = '{-5, 6, -7, 8, -9, 10, -11, 12};
        int end_a;
        obs_n = 0;
        send_group(xa, 0);
        end_a = last_cyc;
        send_group(xb, 0);
        go_idle(14);
        chk("R7", "streamed element count", obs_n, 16);
        check_group("R7 first", xa, 0, end_a);
        check_group("R7 second", xb, 8, last_cyc);
        chk("R7", "no idle between groups", obs_cyc[8] - obs_cyc[7], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ramp();
        t_gaps();
        t_extremes();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule